// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the two least significant address bits for a four-beat burst access. When an access starts, the caller pulses a load strobe together with the starting low address. On each later cycle in which the active-low advance input is low, the block moves to the next beat. While advance is high, the current address is held, which suspends the burst.

Two beat orders are supported, and an order input picks one at run time. In interleaved order each beat address is the start value XORed with the beat index. In linear order each beat address is the start value plus the beat index, modulo four. A flag marks the final beat of the group.

The order input is registered, so a change on it takes effect one cycle later. Advancing past the fourth beat wraps back to the first address and then repeats the same order.

Top module: `burst_seq2`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `addr` is 0 and `last` is 0, and the registered order is linear.
- R2: A clock edge with `load` high makes `addr` equal to the `start` value sampled at that edge and sets the beat index to 0, so `last` is low.
- R3: With `mode` registered high (interleaved), `addr` equals start XOR beat index. For example, start 01 gives 01, 00, 11, 10.
- R4: With `mode` registered low (linear), `addr` equals (start + beat index) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R5: A clock edge with `load` low and `adv_n` low increments the beat index by exactly one.
- R6: A clock edge with `load` low and `adv_n` high keeps the beat index unchanged. If `mode` is also unchanged, `addr` stays the same.
- R7: When `load` and `adv_n` low occur at the same edge, the load wins: the beat index becomes 0, not 1.
- R8: Advancing from beat index 3 returns to beat index 0, so `addr` is the start value again, and the same order continues.
- R9: `mode` is sampled on the clock edge. A change on it alters `addr` only after the next rising edge and never combinationally.
- R10: `last` is high exactly when the beat index is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Start a burst from `start` |
| start | input | CNT_W | Starting low address bits |
| adv_n | input | 1 | Active-low advance; high suspends |
| mode | input | 1 | 1 = interleaved order, 0 = linear order |
| addr | output | CNT_W | Current burst low address |
| last | output | 1 | High on the final beat of the group |

## Verification
Every result appears one edge after its stimulus. A load, an advance or a mode change sampled at a rising edge shows on `addr` and `last` once that edge has passed, with nothing taking effect before it. The bench drives its inputs on the falling edge. It compares the outputs one time unit later against the reference model's state before the edge, which shows that no input reaches the outputs combinationally. It then compares again on the next falling edge, after its model has absorbed the rising edge.

// File: rtl/burst_seq2.sv
module burst_seq2 #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] start,
  input  logic             adv_n,
  input  logic             mode,
  output logic [CNT_W-1:0] addr,
  output logic             last
);
  localparam logic [CNT_W-1:0] FINAL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] beat_q;
  logic             ilv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      ilv_q  <= 1'b0;
    end else begin
      ilv_q <= mode;
      if (load) begin
        base_q <= start;
        beat_q <= '0;
      end else if (!adv_n) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign addr = ilv_q ? (base_q ^ beat_q) : (base_q + beat_q);
  assign last = (beat_q == FINAL);
endmodule

module burst_seq2_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic [CNT_W-1:0] start,
  input logic             adv_n,
  input logic             mode,
  input logic [CNT_W-1:0] addr,
  input logic             last
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr == $past(start)) && !last);

  a_r7_load_beats_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !adv_n) |=> !last && (addr == $past(start)));

  a_r6_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!load && adv_n && $stable(mode)) |=> $stable(addr) && $stable(last));

  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!load && !adv_n && !mode && $stable(mode)) |=> addr == $past(addr) + 1'b1);

  a_r8_interleave_wrap: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!load && !adv_n && mode && $stable(mode) && last) |=> !last && (addr == ($past(addr) ^ ALL1)));

  a_r10_last_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n && last) |=> !last);
endmodule

bind burst_seq2 burst_seq2_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_burst_seq2.sv
module test_burst_seq2;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [1:0] start = 2'd0;
  logic       adv_n = 1'b1;
  logic       mode = 1'b0;
  logic [1:0] addr;
  logic       last;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int m_base = 0;
  int m_beat = 0;
  int m_ilv  = 0;

  burst_seq2 i_burst_seq2 (
    .clk(clk), .rst_n(rst_n), .load(load), .start(start),
    .adv_n(adv_n), .mode(mode), .addr(addr), .last(last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_addr();
    if (m_ilv != 0) return m_base ^ m_beat;
    return (m_base + m_beat) % 4;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (int'(addr) != exp_addr()) begin
      errors++;
      $display("FAIL %s addr actual=%0d expected=%0d", tag, addr, exp_addr());
    end
    checks++;
    if (int'(last) != int'(m_beat == 3)) begin
      errors++;
      $display("FAIL %s last actual=%0d expected=%0d", tag, last, m_beat == 3);
    end
  endtask

  // drive at falling edge, check no combinational effect, then check after rising edge
  task automatic cyc(input bit ld, input int st, input bit av_n, input bit md, input string tag);
    load = ld; start = 2'(st); adv_n = av_n; mode = md;
    #1 compare({tag, "/R9-pre"});
    @(posedge clk);
    if (ld) begin m_base = st; m_beat = 0; end
    else if (!av_n) m_beat = (m_beat + 1) % 4;
    m_ilv = md;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R4/R8: linear from each start, six advances to wrap
    for (int s = 0; s < 4; s++) begin
      cyc(1, s, 1, 0, "R2");
      for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, "R4_R5_R8_R10");
    end
    // R3/R8: interleaved from each start
    cyc(0, 0, 1, 1, "R9");
    for (int s = 0; s < 4; s++) begin
      cyc(1, s, 1, 1, "R2");
      for (int k = 0; k < 6; k++) cyc(0, 0, 0, 1, "R3_R5_R8_R10");
    end
    // R6: suspend mid-burst in both orders
    cyc(1, 2, 1, 1, "R2");
    cyc(0, 0, 0, 1, "R5");
    for (int k = 0; k < 3; k++) cyc(0, 1, 1, 1, "R6");
    cyc(0, 0, 0, 1, "R5");
    cyc(0, 0, 1, 0, "R9_R6");
    cyc(0, 0, 1, 0, "R6");
    // R7: load with advance in same cycle
    cyc(0, 0, 0, 0, "R5");
    cyc(1, 3, 0, 0, "R7");
    cyc(1, 1, 0, 1, "R7");
    // R9: toggle order mid-burst
    cyc(0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 1, "R9");
    cyc(0, 0, 1, 0, "R9");
    cyc(0, 0, 0, 1, "R9_R10");
    // R1: reset mid-burst
    rst_n = 1'b0;
    @(posedge clk); m_base = 0; m_beat = 0; m_ilv = 0;
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    cyc(0, 0, 0, 1, "R5");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule